// File: doc/BRIEF.md
# Serial Receive Engine with Control and Status Register

This block receives serial words and presents them through two byte-wide registers on a simple register bus: a control and status register and a data register. In asynchronous mode it watches a receive line with 16x oversampling and turns each frame into one word. In synchronous master mode it drives a bit clock itself and samples the data line on each falling clock edge. A word is 8 or 9 data bits. The ninth bit is stored as it arrives and is never checked as parity.

Finished words go into a two-entry FIFO together with their ninth bit and their stop-bit status. Software reads the data register to pop the head entry. The error flags follow their own rules. The overrun flag stays set until software writes the continuous-receive enable to 0. The framing flag describes whichever word sits at the FIFO head. A baud tick is supplied from outside, and an external mode input selects synchronous or asynchronous operation.

Top module: `sio_rx_engine`

## Requirements
- R1: After reset the status register (address 0) reads 0x00, the data register (address 1) reads 0x00, and data_avail_o, port_en_o and sclk_o are all 0.
- R2: In the status register, bit 7 is the port enable, bit 6 the 9-bit select, bit 5 the single-receive enable and bit 4 the continuous-receive enable. These four bits are read/write. Bit 3 always reads 0. Bits 2 (framing error), 1 (overrun) and 0 (received 9th bit) are read-only: writes to them have no effect.
- R3: While the port enable is 0, no words are received, port_en_o is 0 and sclk_o stays 0.
- R4: In asynchronous mode, with the port enable and the continuous enable set, a frame is received. A frame is a low start bit, then the data bits least significant first, then a stop bit. Reception begins on a falling edge. The data register returns the byte, and status bit 0 reads 0 for 8-bit frames.
- R5: When the 9-bit select is 1, a frame carries nine data bits. The ninth is shown in status bit 0 while its word is at the FIFO head.
- R6: A start bit is accepted only if at least two of the samples taken at ticks 7, 8 and 9 of the 16-tick start bit are low. A low pulse shorter than that produces no word.
- R7: Status bit 2 reads 1 when the word at the FIFO head had its stop bit sampled low. The bit updates when that word is popped and the next word moves to the head.
- R8: The FIFO holds two words. data_avail_o is 1 while the FIFO is not empty. Reading address 1 pops the head entry. Reading address 1 while the FIFO is empty returns 0.
- R9: If a word completes while the FIFO is full, status bit 1 (overrun) sets and the word is discarded. No further words are accepted while the bit is set. Reads do not clear it. Only a write with bit 4 = 0 clears it.
- R10: In asynchronous mode the single-receive enable has no effect: with it set and the continuous enable clear, no word is received.
- R11: In synchronous master mode, sclk_o pulses 8 or 9 times per word (one pulse per data bit). Data is sampled on each falling sclk_o edge, least significant bit first.
- R12: In synchronous mode, a single-receive enable with the continuous enable clear receives exactly one word. Hardware then clears status bit 5.
- R13: In synchronous mode, with both enables set, continuous reception wins. Words keep arriving until the continuous enable is cleared. The single-receive enable is still cleared after the first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| baud_tick_i | input | 1 | One-cycle tick: 16x bit rate in asynchronous mode, half bit period in synchronous mode |
| sync_mode_i | input | 1 | 1 selects synchronous master mode, 0 selects asynchronous mode |
| rx_i | input | 1 | Receive line (asynchronous) or data line (synchronous) |
| reg_addr_i | input | 1 | Register select: 0 status/control, 1 data |
| reg_wr_i | input | 1 | Write strobe (status register only) |
| reg_rd_i | input | 1 | Read strobe; pops the FIFO when the data register is selected |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| sclk_o | output | 1 | Bit clock driven in synchronous master mode |
| port_en_o | output | 1 | Pins taken over by the serial port |
| data_avail_o | output | 1 | FIFO not empty |

## Verification
The bench sweeps byte patterns through both modes and both frame widths. A wrong bit order or a wrong ninth-bit slot shows up there as a mismatched data or status byte. It sends a bad stop bit followed by a clean frame, so a framing flag that tracked the latest word instead of the head word would read wrong before and after the pop. A third frame is pushed into a full FIFO, and then a fourth. A design that overwrote entries, cleared overrun on a read, or kept accepting words would return the wrong bytes or a cleared flag. Short start glitches, a disabled port, and a single-receive enable in asynchronous mode must all leave the FIFO empty. In synchronous mode the bench counts clock pulses, to catch an engine that fails to clear its single-shot enable or fails to let the continuous enable win.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
  typedef struct packed {
    logic       ferr;
    logic       d9;
    logic [7:0] data;
  } rx_word_t;

  localparam int WORD_W = $bits(rx_word_t);
endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         mem[i] <= '0;
      else if (push_i && wptr == AW'(i))   mem[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_i) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_i)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      count <= count + {{AW{1'b0}}, push_i} - {{AW{1'b0}}, pop_i};
    end
  end

  assign head_o  = mem[rptr];
  assign empty_o = (count == '0);
  assign full_o  = (count == (AW+1)'(DEPTH));

  // R8: data available only ever appears after a write
  assert_rise_after_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(empty_o) |-> $past(push_i));
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
endmodule

// File: rtl/sio_async_rx.sv
module sio_async_rx
  import sio_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     nine_i,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int PH_W = $clog2(OSR);
  localparam int MID  = OSR / 2;
  localparam logic [PH_W-1:0] S_A = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] S_B = PH_W'(MID);
  localparam logic [PH_W-1:0] S_C = PH_W'(MID + 1);

  logic            busy, last, smp_a, smp_b, maj;
  logic [PH_W-1:0] phase;
  logic [3:0]      idx, stop_idx;
  logic [8:0]      shreg;

  assign maj      = (smp_a & smp_b) | (smp_a & rx_i) | (smp_b & rx_i);
  assign stop_idx = nine_i ? 4'd10 : 4'd9;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy   <= 1'b0;
      last   <= 1'b0;
      smp_a  <= 1'b1;
      smp_b  <= 1'b1;
      phase  <= '0;
      idx    <= '0;
      shreg  <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!active_i) begin
        busy  <= 1'b0;
        last  <= 1'b0;
        phase <= '0;
        idx   <= '0;
      end else if (tick_i) begin
        if (!busy) begin
          last <= rx_i;
          if (last && !rx_i) begin
            busy  <= 1'b1;
            phase <= PH_W'(1);
            idx   <= '0;
          end
        end else begin
          phase <= phase + 1'b1;
          if (phase == S_A) smp_a <= rx_i;
          if (phase == S_B) smp_b <= rx_i;
          if (phase == S_C) begin
            if (idx == 4'd0) begin
              if (maj) begin      // false start
                busy <= 1'b0;
                last <= 1'b1;
              end else idx <= idx + 1'b1;
            end else if (idx == stop_idx) begin
              busy        <= 1'b0;
              last        <= maj;
              done_o      <= 1'b1;
              word_o.ferr <= !maj;
              word_o.d9   <= nine_i & shreg[8];
              word_o.data <= nine_i ? shreg[7:0] : shreg[8:1];
            end else begin
              shreg <= {maj, shreg[8:1]};
              idx   <= idx + 1'b1;
            end
          end
        end
      end
    end
  end

  // R4: an inactive engine never completes a word
  assert_idle_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !done_o);
endmodule

// File: rtl/sio_sync_rx.sv
module sio_sync_rx
  import sio_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     active_i,
  input  logic     one_shot_i,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     nine_i,
  output logic     sclk_o,
  output logic     done_o,
  output rx_word_t word_o
);
  logic [3:0] cnt, last_cnt;
  logic       hold;
  logic [8:0] shreg, nxt;

  assign last_cnt = nine_i ? 4'd8 : 4'd7;
  assign nxt      = {rx_i, shreg[8:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o <= 1'b0;
      cnt    <= '0;
      hold   <= 1'b0;
      shreg  <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!active_i) begin
        sclk_o <= 1'b0;
        cnt    <= '0;
        hold   <= 1'b0;
      end else if (tick_i && !hold) begin
        if (!sclk_o) sclk_o <= 1'b1;
        else begin
          sclk_o <= 1'b0;     // falling edge: sample
          shreg  <= nxt;
          if (cnt == last_cnt) begin
            cnt         <= '0;
            done_o      <= 1'b1;
            hold        <= one_shot_i;
            word_o.ferr <= 1'b0;
            word_o.d9   <= nine_i & nxt[8];
            word_o.data <= nine_i ? nxt[7:0] : nxt[8:1];
          end else cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R11: the bit clock moves only on a baud tick
  assert_sclk_steady_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tick_i) |=> $stable(sclk_o));
endmodule

// File: rtl/sio_rx_engine.sv
module sio_rx_engine
  import sio_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_tick_i,
  input  logic       sync_mode_i,
  input  logic       rx_i,
  input  logic       reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       sclk_o,
  output logic       port_en_o,
  output logic       data_avail_o
);
  logic     rx_m, rx_s;
  logic     en_q, nine_q, single_q, cont_q, oerr_q;
  logic     a_active, s_active, a_done, s_done, eng_done;
  rx_word_t a_word, s_word, eng_word, head;
  logic     empty, full, push, pop, stat_wr;
  logic [WORD_W-1:0] head_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
    end
  end

  assign stat_wr  = reg_wr_i && !reg_addr_i;
  assign a_active = en_q && !sync_mode_i && cont_q && !oerr_q;
  assign s_active = en_q &&  sync_mode_i && (cont_q || single_q) && !oerr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      nine_q   <= 1'b0;
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      oerr_q   <= 1'b0;
    end else begin
      if (s_done) single_q <= 1'b0;
      if (eng_done && full) oerr_q <= 1'b1;
      if (stat_wr) begin
        en_q     <= reg_wdata_i[7];
        nine_q   <= reg_wdata_i[6];
        single_q <= reg_wdata_i[5];
        cont_q   <= reg_wdata_i[4];
        if (!reg_wdata_i[4]) oerr_q <= 1'b0;
      end
    end
  end

  sio_async_rx #(.OSR(OSR)) u_async (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (a_active),
    .tick_i   (baud_tick_i),
    .rx_i     (rx_s),
    .nine_i   (nine_q),
    .done_o   (a_done),
    .word_o   (a_word)
  );

  sio_sync_rx u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (s_active),
    .one_shot_i (!cont_q),
    .tick_i     (baud_tick_i),
    .rx_i       (rx_s),
    .nine_i     (nine_q),
    .sclk_o     (sclk_o),
    .done_o     (s_done),
    .word_o     (s_word)
  );

  assign eng_done = a_done | s_done;
  assign eng_word = s_done ? s_word : a_word;
  assign push     = eng_done && !full;
  assign pop      = reg_rd_i && reg_addr_i && !empty;

  sio_rx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (eng_word),
    .pop_i   (pop),
    .head_o  (head_raw),
    .empty_o (empty),
    .full_o  (full)
  );

  assign head = rx_word_t'(head_raw);

  always_comb begin
    if (reg_addr_i) reg_rdata_o = empty ? 8'h00 : head.data;
    else reg_rdata_o = {en_q, nine_q, single_q, cont_q, 1'b0,
                        head.ferr & !empty, oerr_q, head.d9 & !empty};
  end

  assign port_en_o    = en_q;
  assign data_avail_o = !empty;

  assert_overrun_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && full && !stat_wr) |=> oerr_q);
  assert_overrun_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oerr_q && !(stat_wr && !reg_wdata_i[4])) |=> oerr_q);
  assert_sclk_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !sclk_o);
  assert_single_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_done && !stat_wr) |=> !single_q);
endmodule

// File: tb/sio_rx_engine_test.sv
module sio_rx_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BITC       = 16 * TICK_DIV;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sync_sel = 1'b0;
  logic       line_a = 1'b1, slave_bit = 1'b1, rx;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic       sclk, pen, avail;
  int         checks = 0, errors = 0, tdiv = 0;
  logic [8:0] slave_word = '0;
  int         slave_ptr = 0, nb = 8, rises = 0;

  assign rx = sync_sel ? slave_bit : line_a;

  sio_rx_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .sync_mode_i(sync_sel),
    .rx_i(rx), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_o(sclk),
    .port_en_o(pen), .data_avail_o(avail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV-1);
  end

  always @(posedge sclk) begin
    slave_bit <= slave_word[slave_ptr];
    slave_ptr <= (slave_ptr == nb-1) ? 0 : slave_ptr + 1;
    rises     <= rises + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); addr = 1'b0; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0; addr = 1'b0;
  endtask

  task automatic send_async(input logic [8:0] d, input int n, input logic stop);
    line_a = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < n; i++) begin line_a = d[i]; repeat (BITC) @(negedge clk); end
    line_a = stop; repeat (BITC) @(negedge clk);
    line_a = 1'b1; repeat (BITC) @(negedge clk);
  endtask

  task automatic wait_avail(input int lim);
    for (int i = 0; i < lim && !avail; i++) @(negedge clk);
  endtask

  task automatic sync_setup(input logic [8:0] w, input int n);
    slave_word = w; nb = n; slave_ptr = 0; rises = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, pats [8];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'h96};
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_reg(1'b0, v); chk(v == 8'h00, "R1 status", v, 0);
    rd_reg(1'b1, v); chk(v == 8'h00, "R1 data", v, 0);
    chk({avail, pen, sclk} == 3'b000, "R1 outputs", {avail, pen, sclk}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd_reg(1'b0, v); chk(v == 8'h00, "R1 status after release", v, 0);

    // R2 register access
    wr_stat(8'hFF); rd_reg(1'b0, v); chk(v == 8'hF0, "R2 write ones", v, 8'hF0);
    wr_stat(8'h4F); rd_reg(1'b0, v); chk(v == 8'h40, "R2 mixed", v, 8'h40);
    wr_stat(8'h00); rd_reg(1'b0, v); chk(v == 8'h00, "R2 zero", v, 0);

    // R3 disabled port
    wr_stat(8'h10);
    chk(pen == 1'b0, "R3 port_en", pen, 0);
    send_async(9'h0A5, 8, 1'b1);
    chk(avail == 1'b0, "R3 no word", avail, 0);
    chk(sclk == 1'b0, "R3 sclk", sclk, 0);

    // R10 single enable ignored in async mode
    wr_stat(8'hA0);
    send_async(9'h05A, 8, 1'b1);
    chk(avail == 1'b0, "R10 no word", avail, 0);
    rd_reg(1'b0, v); chk(v == 8'hA0, "R10 status", v, 8'hA0);

    // R4 async 8-bit sweep
    wr_stat(8'h90);
    chk(pen == 1'b1, "R4 port_en", pen, 1);
    foreach (pats[k]) begin
      send_async({1'b0, pats[k]}, 8, 1'b1);
      chk(avail == 1'b1, "R8 avail", avail, 1);
      rd_reg(1'b0, v); chk(v == 8'h90, "R4 status", v, 8'h90);
      rd_reg(1'b1, v); chk(v == pats[k], "R4 data", v, pats[k]);
      chk(avail == 1'b0, "R8 empty after pop", avail, 0);
    end
    rd_reg(1'b1, v); chk(v == 8'h00, "R8 empty read", v, 0);

    // R5 async 9-bit
    wr_stat(8'hD0);
    for (int k = 0; k < 4; k++) begin
      logic [8:0] w;
      w = {k[0], pats[k+2]};
      send_async(w, 9, 1'b1);
      rd_reg(1'b0, v); chk(v == {7'b1101000, w[8]}, "R5 status d9", v, {7'b1101000, w[8]});
      rd_reg(1'b1, v); chk(v == w[7:0], "R5 data", v, w[7:0]);
    end

    // R6 start glitch
    wr_stat(8'h90);
    line_a = 1'b0; repeat (2 * TICK_DIV) @(negedge clk); line_a = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    chk(avail == 1'b0, "R6 glitch rejected", avail, 0);
    send_async(9'h0C7, 8, 1'b1);
    rd_reg(1'b1, v); chk(v == 8'hC7, "R6 recovery", v, 8'hC7);

    // R7 framing follows head
    send_async(9'h03C, 8, 1'b0);
    send_async(9'h0C3, 8, 1'b1);
    rd_reg(1'b0, v); chk(v == 8'h94, "R7 ferr on head", v, 8'h94);
    rd_reg(1'b1, v); chk(v == 8'h3C, "R7 bad word data", v, 8'h3C);
    rd_reg(1'b0, v); chk(v == 8'h90, "R7 ferr cleared by pop", v, 8'h90);
    rd_reg(1'b1, v); chk(v == 8'hC3, "R7 next data", v, 8'hC3);

    // R9 overrun
    send_async(9'h011, 8, 1'b1);
    send_async(9'h022, 8, 1'b1);
    rd_reg(1'b0, v); chk(v == 8'h90, "R8 full no overrun", v, 8'h90);
    send_async(9'h033, 8, 1'b1);
    rd_reg(1'b0, v); chk(v == 8'h92, "R9 overrun set", v, 8'h92);
    send_async(9'h044, 8, 1'b1);
    rd_reg(1'b1, v); chk(v == 8'h11, "R9 first kept", v, 8'h11);
    rd_reg(1'b1, v); chk(v == 8'h22, "R9 second kept", v, 8'h22);
    chk(avail == 1'b0, "R9 discarded words", avail, 0);
    rd_reg(1'b0, v); chk(v == 8'h92, "R9 reads keep flag", v, 8'h92);
    wr_stat(8'h9F); rd_reg(1'b0, v); chk(v == 8'h92, "R9 write cont=1 keeps", v, 8'h92);
    wr_stat(8'h80); rd_reg(1'b0, v); chk(v == 8'h80, "R9 cleared", v, 8'h80);
    wr_stat(8'h90);
    send_async(9'h055, 8, 1'b1);
    rd_reg(1'b1, v); chk(v == 8'h55, "R9 accepts again", v, 8'h55);

    // R11 R12 sync single-shot sweep
    wr_stat(8'h00);
    sync_sel = 1'b1;
    for (int k = 0; k < 8; k++) begin
      logic [8:0] w;
      int n;
      n = (k < 4) ? 8 : 9;
      w = {k[1], pats[k]};
      sync_setup(w, n);
      wr_stat((n == 9) ? 8'hE0 : 8'hA0);
      wait_avail(400);
      repeat (100) @(negedge clk);
      chk(rises == n, "R11 sclk pulses", rises, n);
      rd_reg(1'b0, v);
      chk(v == {1'b1, n == 9, 5'b00000, (n == 9) & w[8]}, "R12 single cleared",
          v, {1'b1, n == 9, 5'b00000, (n == 9) & w[8]});
      rd_reg(1'b1, v); chk(v == w[7:0], "R11 sync data", v, w[7:0]);
      chk(avail == 1'b0, "R12 one word only", avail, 0);
    end

    // R13 continuous overrides single
    sync_setup(9'h0B6, 8);
    wr_stat(8'hB0);
    repeat (150) @(negedge clk);
    wr_stat(8'h80);
    chk(rises > 8, "R13 keeps clocking", rises, 9);
    rd_reg(1'b0, v); chk(v == 8'h80, "R13 status", v, 8'h80);
    rd_reg(1'b1, v); chk(v == 8'hB6, "R13 word one", v, 8'hB6);
    rd_reg(1'b1, v); chk(v == 8'hB6, "R13 word two", v, 8'hB6);
    repeat (100) @(negedge clk);
    chk(sclk == 1'b0 && avail == 1'b0, "R13 stopped", {sclk, avail}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule